// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller

This block gathers interrupt events for a small processor core and turns them into one vector request at a time. Eight request flags feed seven vector groups: the first group is shared by a periodic timer tick and a both-edge pin, and the others each carry one source. Each flag has its own enable bit, and a master enable gates all of them. A three-bit priority field can lift one group above the rest. A two-bit nesting status decides which requests may still interrupt the handler that is running. A separate wake-only flag, set by a rising edge on a test pin or a falling edge on any key line, never produces a vector.

The core sees `vec_req` with a group index. It answers with `vec_ack` when it jumps to the vector. It pulses `vec_ret` when the handler ends. Software uses a small write port to set the enables, the master bit and the priority field, and to clear flags. `wake` tells the power manager that some enabled request is pending.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `vec_req`, `vec_idx` and `wake` are 0. All flags, enables, the master bit and the priority field are 0, and the nesting status is open.
- R2: A group is requested only when one of its flags is set, that flag's enable bit is 1, and the master bit is 1. Flag/enable bit order: 0 tick, 1 INT4 pin, 2 INT0 pin, 3 INT1 pin, 4 serial done, 5 timer match, 6 CE falling, 7 gate close. Groups: 0 = bits 0 and 1, and group g = bit g+1 for g from 1 to 6.
- R3: With priority field 0, the lowest-numbered group with a live request wins. The losing requests stay pending and are served after the return.
- R4: A priority field value k from 1 to 7 makes group k-1 high priority. When that group has a live request it wins over all others.
- R5: Nesting status: 00 accepts any group, 01 accepts only the high group, and 10 accepts nothing. An acknowledge moves 00 to 01, or to 10 when the group taken is high, and moves 01 to 10. `vec_ret` restores the status saved by the matching acknowledge.
- R6: An acknowledge clears the flag of the group taken. For group 0, only the flag that is enabled is cleared. When both group-0 enables are set, both flags are kept, and the group requests again once the status allows.
- R7: The INT4 pin sets its flag on both edges. INT0 and INT1 set their flags on a rising edge when their `edge_rise` input is 1, and on a falling edge when it is 0.
- R8: INT0 passes through a filter that takes FILT_LEN consecutive equal samples (default 2). A one-cycle glitch sets no flag.
- R9: The wake-only flag sets on an INT2 rising edge or a falling edge on any key line. It never raises `vec_req`. It raises `wake`, and it is cleared only by a write of bit 0 to address 3.
- R10: `wake` is 1 whenever an enabled flag is set, even while the master bit is 0.
- R11: Write port: address 0 writes the eight enable bits. Address 1 writes the priority field from bits 2:0 and the master bit from bit 3. Address 2 clears every flag whose data bit is 1. Address 3 bit 0 clears the wake-only flag.
- R12: `vec_req` is low in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_tick | input | 1 | Periodic timer tick pulse |
| evt_serial | input | 1 | Serial transfer done pulse |
| evt_match | input | 1 | Timer compare match pulse |
| evt_ce_fall | input | 1 | Chip-enable falling pulse |
| evt_gate | input | 1 | Frequency-counter gate close pulse |
| pin_int4 | input | 1 | Both-edge interrupt pin |
| pin_int0 | input | 1 | Filtered interrupt pin |
| pin_int1 | input | 1 | Interrupt pin |
| edge_rise0 | input | 1 | INT0 edge: 1 rising, 0 falling |
| edge_rise1 | input | 1 | INT1 edge: 1 rising, 0 falling |
| pin_int2 | input | 1 | Wake-only rising-edge pin |
| pin_key | input | KEY_W | Key lines, falling edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| vec_ack | input | 1 | Core took the vector |
| vec_ret | input | 1 | Handler returned |
| vec_req | output | 1 | Vector request |
| vec_idx | output | 3 | Requested group |
| wake | output | 1 | Power-down release |

## Verification
The hardest overlap is a new high-priority request that arrives while a low-priority handler is running. In that case nesting status, arbitration and the acknowledge path all act in one window. The bench starts a serial handler, raises INT1 while INT1 is the high group, and expects the nested vector. It then expects nothing until two returns have unwound the status. A second overlap comes from two event pulses set in the same cycle: the scoreboard must see the winner first and the loser only after the return.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    NEST_OPEN = 2'b00,
    NEST_LOW  = 2'b01,
    NEST_HIGH = 2'b10
  } nest_t;

  localparam logic [1:0] ADR_ENABLE = 2'd0;
  localparam logic [1:0] ADR_CTRL   = 2'd1;
  localparam logic [1:0] ADR_CLEAR  = 2'd2;
  localparam logic [1:0] ADR_QCLEAR = 2'd3;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int FILT_LEN = 1,
  parameter bit BOTH     = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_o
);
  logic [FILT_LEN-1:0] samp_q;
  logic                lvl_q, lvl_n;

  generate
    if (FILT_LEN == 1) begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) samp_q <= '0;
        else     samp_q <= pin;
      end
    end else begin : g_filt
      always_ff @(posedge clk) begin
        if (rst) samp_q <= '0;
        else     samp_q <= {samp_q[FILT_LEN-2:0], pin};
      end
    end
  endgenerate

  always_comb begin
    lvl_n = lvl_q;
    if (&samp_q)       lvl_n = 1'b1;
    else if (~|samp_q) lvl_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_n;
  end

  assign edge_o = (lvl_n != lvl_q) && (BOTH || (lvl_n == rise_sel));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_GRP = 7,
  localparam int IDX_W  = $clog2(NUM_GRP),
  localparam int PRIO_W = $clog2(NUM_GRP + 1)
) (
  input  logic [NUM_GRP-1:0] act,
  input  logic [PRIO_W-1:0]  prio,
  input  nest_t              status,
  output logic               take,
  output logic [IDX_W-1:0]   win_idx
);
  logic [IDX_W-1:0] low_idx, hi_idx;
  logic             hi_valid;

  always_comb begin
    low_idx = '0;
    for (int i = NUM_GRP - 1; i >= 0; i--)
      if (act[i]) low_idx = IDX_W'(i);
  end

  assign hi_idx   = IDX_W'(prio - PRIO_W'(1));
  assign hi_valid = (prio != '0) && (int'(prio) <= NUM_GRP) && act[hi_idx];
  assign win_idx  = hi_valid ? hi_idx : low_idx;
  assign take     = (|act) && ((status == NEST_OPEN) ||
                               (status == NEST_LOW && hi_valid));
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  logic  push_high,
  input  logic  pop,
  output nest_t status
);
  nest_t            stk [DEPTH];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (push && ptr < PTR_W'(DEPTH)) stk[ptr] <= status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= NEST_OPEN;
      ptr    <= '0;
    end else if (push && ptr < PTR_W'(DEPTH)) begin
      ptr    <= ptr + PTR_W'(1);
      status <= (status == NEST_OPEN && !push_high) ? NEST_LOW : NEST_HIGH;
    end else if (pop && ptr != '0) begin
      ptr    <= ptr - PTR_W'(1);
      status <= stk[ptr - PTR_W'(1)];
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_GRP   = 7,
  parameter int FILT_LEN  = 2,
  parameter int STK_DEPTH = 4,
  parameter int KEY_W     = 4,
  localparam int NFLAG    = NUM_GRP + 1,
  localparam int IDX_W    = $clog2(NUM_GRP),
  localparam int PRIO_W   = $clog2(NUM_GRP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_tick,
  input  logic             evt_serial,
  input  logic             evt_match,
  input  logic             evt_ce_fall,
  input  logic             evt_gate,
  input  logic             pin_int4,
  input  logic             pin_int0,
  input  logic             pin_int1,
  input  logic             edge_rise0,
  input  logic             edge_rise1,
  input  logic             pin_int2,
  input  logic [KEY_W-1:0] pin_key,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [NFLAG-1:0] wr_data,
  input  logic             vec_ack,
  input  logic             vec_ret,
  output logic             vec_req,
  output logic [IDX_W-1:0] vec_idx,
  output logic             wake
);
  logic [NFLAG-1:0]   flags_q, en_q, svc, set_v, clr_v;
  logic               master_q, quasi_q;
  logic [PRIO_W-1:0]  prio_q;
  logic [NUM_GRP-1:0] grp_act;
  logic               e4, e0, e1, e2, take, acked, taken_high;
  logic [KEY_W-1:0]   key_fall;
  logic [IDX_W-1:0]   win_idx;
  nest_t              nest_status;

  irq_pin_edge #(.FILT_LEN(1), .BOTH(1'b1)) u_e4 (
    .clk(clk), .rst(rst), .pin(pin_int4), .rise_sel(1'b1), .edge_o(e4));
  irq_pin_edge #(.FILT_LEN(FILT_LEN), .BOTH(1'b0)) u_e0 (
    .clk(clk), .rst(rst), .pin(pin_int0), .rise_sel(edge_rise0), .edge_o(e0));
  irq_pin_edge #(.FILT_LEN(1), .BOTH(1'b0)) u_e1 (
    .clk(clk), .rst(rst), .pin(pin_int1), .rise_sel(edge_rise1), .edge_o(e1));
  irq_pin_edge #(.FILT_LEN(1), .BOTH(1'b0)) u_e2 (
    .clk(clk), .rst(rst), .pin(pin_int2), .rise_sel(1'b1), .edge_o(e2));

  generate
    for (genvar k = 0; k < KEY_W; k++) begin : g_key
      irq_pin_edge #(.FILT_LEN(1), .BOTH(1'b0)) u_key (
        .clk(clk), .rst(rst), .pin(pin_key[k]), .rise_sel(1'b0),
        .edge_o(key_fall[k]));
    end
  endgenerate

  // flag sources in bit order tick, INT4, INT0, INT1, serial, match, CE, gate
  always_comb begin
    set_v = '0;
    set_v[0] = evt_tick;
    set_v[1] = e4;
    set_v[2] = e0;
    set_v[3] = e1;
    set_v[4] = evt_serial;
    set_v[5] = evt_match;
    set_v[6] = evt_ce_fall;
    set_v[7] = evt_gate;
  end

  assign svc = flags_q & en_q & {NFLAG{master_q}};

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      if (g == 0) begin : g_shared
        assign grp_act[g] = svc[0] | svc[1];
      end else begin : g_single
        assign grp_act[g] = svc[g+1];
      end
    end
  endgenerate

  irq_arbiter #(.NUM_GRP(NUM_GRP)) u_arb (
    .act(grp_act), .prio(prio_q), .status(nest_status),
    .take(take), .win_idx(win_idx));

  assign acked      = vec_ack && vec_req;
  assign taken_high = (prio_q != '0) && (vec_idx == IDX_W'(prio_q - PRIO_W'(1)));

  irq_nest_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(acked), .push_high(taken_high),
    .pop(vec_ret && !acked), .status(nest_status));

  always_comb begin
    clr_v = '0;
    if (wr_en && wr_addr == ADR_CLEAR) clr_v = wr_data;
    if (acked) begin
      if (vec_idx == '0) begin
        if (!(en_q[0] && en_q[1])) clr_v[1:0] = clr_v[1:0] | en_q[1:0];
      end else begin
        clr_v[vec_idx + IDX_W'(1)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      en_q     <= '0;
      master_q <= 1'b0;
      prio_q   <= '0;
      quasi_q  <= 1'b0;
      vec_req  <= 1'b0;
      vec_idx  <= '0;
      wake     <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_v) | set_v;
      if (wr_en && wr_addr == ADR_ENABLE) en_q <= wr_data;
      if (wr_en && wr_addr == ADR_CTRL) begin
        prio_q   <= wr_data[PRIO_W-1:0];
        master_q <= wr_data[PRIO_W];
      end
      if (e2 || (|key_fall))                               quasi_q <= 1'b1;
      else if (wr_en && wr_addr == ADR_QCLEAR && wr_data[0]) quasi_q <= 1'b0;
      vec_req <= take && !acked;
      vec_idx <= win_idx;
      wake    <= (|(flags_q & en_q)) | quasi_q;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int IDX_W   = 3,
  parameter int NUM_GRP = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             vec_req,
  input logic [IDX_W-1:0] vec_idx,
  input logic             vec_ack,
  input logic             master_q,
  input logic [1:0]       nest_status
);
  assert_req_drops_R12: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && vec_req) |=> !vec_req);

  assert_no_req_masked_R2: assert property (@(posedge clk) disable iff (rst)
    !master_q |=> !vec_req);

  assert_status_legal_R5: assert property (@(posedge clk) disable iff (rst)
    nest_status != 2'b11);

  assert_closed_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (nest_status == 2'b10) |=> !vec_req);

  assert_take_advances_R5: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && vec_req && nest_status == 2'b00) |=> (nest_status != 2'b00));

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> (int'(vec_idx) < NUM_GRP));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.IDX_W(IDX_W), .NUM_GRP(NUM_GRP)) u_chk (
  .clk(clk), .rst(rst), .vec_req(vec_req), .vec_idx(vec_idx),
  .vec_ack(vec_ack), .master_q(master_q), .nest_status(nest_status));

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic clk = 1'b0, rst = 1'b1;
  logic evt_tick = 0, evt_serial = 0, evt_match = 0, evt_ce_fall = 0, evt_gate = 0;
  logic pin_int4 = 0, pin_int0 = 0, pin_int1 = 0, edge_rise0 = 1, edge_rise1 = 1;
  logic pin_int2 = 0;
  logic [3:0] pin_key = 4'h0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic vec_ack = 0, vec_ret = 0;
  logic vec_req, wake;
  logic [2:0] vec_idx;

  int errors = 0, checks = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst(rst), .evt_tick(evt_tick), .evt_serial(evt_serial),
    .evt_match(evt_match), .evt_ce_fall(evt_ce_fall), .evt_gate(evt_gate),
    .pin_int4(pin_int4), .pin_int0(pin_int0), .pin_int1(pin_int1),
    .edge_rise0(edge_rise0), .edge_rise1(edge_rise1), .pin_int2(pin_int2),
    .pin_key(pin_key), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vec_ack(vec_ack), .vec_ret(vec_ret), .vec_req(vec_req),
    .vec_idx(vec_idx), .wake(wake));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 0;
  endtask

  // monitor: compare the taken vector with the scoreboard head
  always @(negedge clk) begin
    if (!rst && vec_ack && vec_req) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual=%0d expected=none", vec_idx);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(vec_idx), e);
      end
    end
  end

  // driver: expect a vector, wait for it, acknowledge
  task automatic service(input int idx, input string req);
    int n;
    exp_q.push_back(idx);
    tag_q.push_back(req);
    n = 0;
    while (!vec_req && n < 30) begin step(1); n++; end
    if (!vec_req) begin
      void'(exp_q.pop_back());
      void'(tag_q.pop_back());
      check({req, " request missing"}, 0, 1);
    end else begin
      vec_ack = 1; step(1); vec_ack = 0;
      step(1);
      check("R12 request dropped after ack", int'(vec_req), 0);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int seen;
    seen = 0;
    repeat (n) begin step(1); if (vec_req) seen = 1; end
    check(req, seen, 0);
  endtask

  task automatic ret();
    vec_ret = 1; step(1); vec_ret = 0; step(1);
  endtask

  task automatic pulse_evt(input int which);
    case (which)
      0: evt_tick = 1;
      4: evt_serial = 1;
      5: evt_match = 1;
      6: evt_ce_fall = 1;
      default: evt_gate = 1;
    endcase
    step(1);
    evt_tick = 0; evt_serial = 0; evt_match = 0; evt_ce_fall = 0; evt_gate = 0;
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    // R1 reset state
    check("R1 vec_req", int'(vec_req), 0);
    check("R1 vec_idx", int'(vec_idx), 0);
    check("R1 wake", int'(wake), 0);

    // R2/R11: master on, serial flag not enabled
    wr(2'd1, 8'h08);
    pulse_evt(4);
    quiet(6, "R2 disabled flag gives no vector");
    check("R10 disabled flag gives no wake", int'(wake), 0);
    wr(2'd0, 8'h10);
    service(3, "R2 serial vector");
    ret();

    // R3 simultaneous serial + CE fall, default order
    wr(2'd0, 8'h50);
    evt_serial = 1; evt_ce_fall = 1; step(1); evt_serial = 0; evt_ce_fall = 0;
    service(3, "R3 winner serial");
    quiet(8, "R5 low status blocks low request");
    ret();
    service(5, "R3 pending CE after return");
    ret();

    // R4 priority 6 makes CE group high
    wr(2'd1, 8'h0E);
    evt_serial = 1; evt_ce_fall = 1; step(1); evt_serial = 0; evt_ce_fall = 0;
    service(5, "R4 high CE wins");
    quiet(8, "R5 high status blocks all");
    ret();
    service(3, "R4 serial after return");
    ret();

    // R5 preemption: INT1 group high, serial handler running
    wr(2'd1, 8'h0B);
    wr(2'd0, 8'h18);
    edge_rise1 = 1;
    pulse_evt(4);
    service(3, "R5 low handler");
    pin_int1 = 1; step(2);
    service(2, "R5 nested high preempts");
    quiet(6, "R5 nested status closed");
    ret();
    quiet(6, "R5 restored low status");
    ret();
    quiet(6, "R5 open with no pending");
    pin_int1 = 0; step(3);

    // R6 shared vector, both enabled: flags kept
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h03);
    pulse_evt(0);
    service(0, "R6 shared first take");
    ret();
    service(0, "R6 shared flag kept");
    wr(2'd2, 8'h01);
    ret();
    quiet(6, "R6 software clear of shared flag");
    // R6 only tick enabled: hardware clear
    wr(2'd0, 8'h01);
    pulse_evt(0);
    service(0, "R6 single shared take");
    ret();
    quiet(6, "R6 hardware clear");

    // R7 INT4 both edges
    wr(2'd0, 8'h02);
    pin_int4 = 1; step(1);
    service(0, "R7 INT4 rising");
    ret();
    pin_int4 = 0; step(1);
    service(0, "R7 INT4 falling");
    ret();

    // R8 INT0 glitch filtered, then a wide pulse
    wr(2'd0, 8'h04);
    edge_rise0 = 1;
    pin_int0 = 1; step(1); pin_int0 = 0;
    quiet(8, "R8 glitch rejected");
    pin_int0 = 1; step(4);
    service(1, "R8 wide pulse INT0");
    ret();
    // R7 INT0 falling mode
    edge_rise0 = 0;
    pin_int0 = 0; step(4);
    service(1, "R7 INT0 falling edge");
    ret();
    pin_int0 = 1;
    quiet(8, "R7 INT0 rising ignored in falling mode");

    // R10 wake with master off
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h10);
    pulse_evt(4);
    step(2);
    check("R10 wake with master off", int'(wake), 1);
    quiet(4, "R2 master off blocks vector");
    wr(2'd2, 8'hFF);
    step(2);
    check("R11 clear write drops wake", int'(wake), 0);

    // R9 wake-only flag
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h00);
    pin_key = 4'hF; step(4);
    check("R9 key rising does not set", int'(wake), 0);
    pin_key[2] = 1'b0; step(3);
    check("R9 key falling raises wake", int'(wake), 1);
    quiet(6, "R9 wake-only flag never vectors");
    wr(2'd2, 8'hFF); step(2);
    check("R9 flag clear write ignored", int'(wake), 1);
    wr(2'd3, 8'h01); step(2);
    check("R9 software clear", int'(wake), 0);
    pin_int2 = 1; step(3);
    check("R9 INT2 rising raises wake", int'(wake), 1);
    wr(2'd3, 8'h01); step(2);
    check("R9 second clear", int'(wake), 0);

    check("scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule